// File: doc/BRIEF.md
# Indirect Threshold Register Bank Controller

This block is the configuration front end of a fast threshold-monitoring unit. It keeps three banks of sixteen 16-bit entries: a list bank, a low-threshold bank and a high-threshold bank. Software reaches all 48 entries through a single data register. A 16-bit control register holds an enable bit, two bank-select bits and a 4-bit entry index.

The bank-select bits choose which bank the data register addresses, and the index chooses the entry. The index steps forward by one after every data-register access, so software can stream a whole bank with consecutive accesses after writing the starting index once. Setting the enable bit starts a fixed wake-up count. The `unit_awake` output rises only when that count has elapsed.

The register bus is a plain synchronous strobe interface: one address, a write strobe and a read strobe per cycle. There is no back-pressure, so every access completes in the cycle its strobe is high. Read data is registered and appears one cycle after the read strobe. The address map is control register at address 0 and data register at address 1. All other addresses are unmapped.

Top module: `thrbank_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, every entry of all three banks reads 0x0000, `bus_rdata` is 0 and `unit_awake` is 0.
- R2: Control register fields are enable at bit 12, list select at bit 7, high select at bit 4, and index at bits 3:0. Bits 15:13, 11:8 and 6:5 always read 0, and writing 1 to them has no effect.
- R3: The data register addresses a bank chosen from the control register. With list select 1 it addresses the list bank, whatever high select is. With list select 0 and high select 0 it addresses the low bank. With list select 0 and high select 1 it addresses the high bank. A write changes only the addressed entry.
- R4: A control write that changes enable from 0 to 1 holds `unit_awake` low for 119 clock edges after the writing edge, and `unit_awake` rises on the 120th edge. Writing enable = 1 while it is already 1 does not restart the count. A write that clears enable drops `unit_awake` at the writing edge. Clearing enable and then setting it again restarts the full count.
- R5: The index increments by one, wrapping from 15 to 0, after every read or write of the data register. A control-register read returns the current index.
- R6: Read data is registered: `bus_rdata` shows the addressed value after the clock edge that samples `bus_rd`, and it holds its value in cycles without a read strobe.
- R7: A data-register access with both strobes high writes the new value and returns the entry's previous content. It increments the index once.
- R8: Writes to unmapped addresses (2 and 3) change no state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (2) | Register address: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| unit_awake | output | 1 | High once the wake-up count after enabling has elapsed |

## Verification
The assertions check these rules on every cycle:
- reserved control bits read back as zero;
- every data access moves the index by exactly one, and the index holds while there is no access;
- read data holds when there is no read strobe;
- unmapped reads return zero;
- `unit_awake` is never high without the enable bit;
- `unit_awake` rises exactly when the checker's own cycle count since enabling reaches the wake-up length.

Some behaviour can only be shown by the bench's scenarios:
- which bank a given select pattern reaches, and that a write leaves the other banks untouched;
- the wrap of the index from 15 to 0;
- the old-value return of a combined read-write;
- that re-writing the enable bit while already enabled leaves the count alone, while a clear-and-set restarts it.

// File: rtl/thrb_pkg.sv
package thrb_pkg;
  localparam int CTRL_W    = 16;
  localparam int EN_BIT    = 12;
  localparam int LIST_BIT  = 7;
  localparam int HISEL_BIT = 4;
  localparam int CTRL_ADDR = 0;
  localparam int DATA_ADDR = 1;
  localparam int NUM_BANKS = 3;

  typedef enum logic [1:0] {
    BANK_LOW  = 2'd0,
    BANK_HIGH = 2'd1,
    BANK_LIST = 2'd2
  } bank_e;

  function automatic bank_e pick_bank(input logic list_sel, input logic hi_sel);
    if (list_sel)    return BANK_LIST;
    else if (hi_sel) return BANK_HIGH;
    else             return BANK_LOW;
  endfunction
endpackage

// File: rtl/thrb_ctrl_reg.sv
module thrb_ctrl_reg #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             en_in,
  input  logic             list_in,
  input  logic             hi_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             idx_step,
  output logic             en_q,
  output logic             list_q,
  output logic             hi_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             en_rise,
  output logic             en_fall
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      list_q <= 1'b0;
      hi_q   <= 1'b0;
      idx_q  <= '0;
    end else if (ctrl_we) begin
      en_q   <= en_in;
      list_q <= list_in;
      hi_q   <= hi_in;
      idx_q  <= idx_in;
    end else if (idx_step) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign en_rise = ctrl_we &&  en_in && !en_q;
  assign en_fall = ctrl_we && !en_in &&  en_q;
endmodule

// File: rtl/thrb_wake_timer.sv
module thrb_wake_timer #(
  parameter int WAKE_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic en,
  output logic ready
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (stop || !en) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt_q == LAST) ready <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/thrb_entry_bank.sv
module thrb_entry_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/thrbank_ctrl.sv
module thrbank_ctrl
  import thrb_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int WAKE_CYC = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              unit_awake
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             ctrl_hit, data_hit, ctrl_we, data_we, data_acc;
  logic             en_q, list_q, hi_q, en_rise, en_fall;
  logic [IDX_W-1:0] idx_q;
  bank_e            sel;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic [DATA_W-1:0] ctrl_word;

  assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign data_hit = (bus_addr == ADDR_W'(DATA_ADDR));
  assign ctrl_we  = bus_wr && ctrl_hit;
  assign data_we  = bus_wr && data_hit;
  assign data_acc = (bus_wr || bus_rd) && data_hit;

  thrb_ctrl_reg #(.IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .en_in    (bus_wdata[EN_BIT]),
    .list_in  (bus_wdata[LIST_BIT]),
    .hi_in    (bus_wdata[HISEL_BIT]),
    .idx_in   (bus_wdata[IDX_W-1:0]),
    .idx_step (data_acc),
    .en_q     (en_q),
    .list_q   (list_q),
    .hi_q     (hi_q),
    .idx_q    (idx_q),
    .en_rise  (en_rise),
    .en_fall  (en_fall)
  );

  thrb_wake_timer #(.WAKE_CYC(WAKE_CYC)) wake_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (en_rise),
    .stop  (en_fall),
    .en    (en_q),
    .ready (unit_awake)
  );

  assign sel = pick_bank(list_q, hi_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = data_we && (sel == bank_e'(b));
    thrb_entry_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .idx   (idx_q),
      .wdata (bus_wdata),
      .rdata (bank_rd[b])
    );
  end

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[EN_BIT]         = en_q;
    ctrl_word[LIST_BIT]       = list_q;
    ctrl_word[HISEL_BIT]      = hi_q;
    ctrl_word[IDX_W-1:0]      = idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (ctrl_hit)      bus_rdata <= ctrl_word;
      else if (data_hit) bus_rdata <= bank_rd[int'(sel)];
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/thrb_chk.sv
module thrb_chk #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4,
  parameter int WAKE_CYC = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wr_en_bit,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              unit_awake,
  input logic              en_q,
  input logic [IDX_W-1:0]  idx_q
);
  localparam int WC_W = $clog2(WAKE_CYC + 2);
  localparam logic [WC_W-1:0] WC_MAX = {WC_W{1'b1}};

  logic [WC_W-1:0] wait_cnt;
  logic ctrl_a, data_a;

  assign ctrl_a = (bus_addr == ADDR_W'(0));
  assign data_a = (bus_addr == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                                wait_cnt <= '0;
    else if (bus_wr && ctrl_a && wr_en_bit && !en_q) wait_cnt <= '0;
    else if (en_q && wait_cnt != WC_MAX)       wait_cnt <= wait_cnt + 1'b1;
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ctrl_a) |=> (bus_rdata[15:13] == 3'b0 && bus_rdata[11:8] == 4'b0 && bus_rdata[6:5] == 2'b0)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && data_a) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> $stable(idx_q)); // R5
  AST_AWAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    unit_awake |-> en_q); // R4
  AST_WAKE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_awake) |-> (wait_cnt == WC_W'(WAKE_CYC))); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !ctrl_a && !data_a) |=> (bus_rdata == '0)); // R8
endmodule

bind thrbank_ctrl thrb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .WAKE_CYC(WAKE_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .wr_en_bit  (bus_wdata[12]),
  .bus_rdata  (bus_rdata),
  .unit_awake (unit_awake),
  .en_q       (en_q),
  .idx_q      (idx_q)
);

// File: tb/thrbank_ctrl_tb.sv
module thrbank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        unit_awake;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thrbank_ctrl #(.ADDR_W(2), .DATA_W(16), .DEPTH(16), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unit_awake(unit_awake)
  );

  // op: 0 write only, 1 read and compare, 2 read+write and compare
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 4'd3}, // R3 low bank, index 0
    '{2'd0, 2'd1, 16'h1111, 16'h0000, 4'd3},
    '{2'd0, 2'd1, 16'h2222, 16'h0000, 4'd3},
    '{2'd0, 2'd0, 16'h0010, 16'h0000, 4'd3}, // R3 high bank
    '{2'd0, 2'd1, 16'hAAAA, 16'h0000, 4'd3},
    '{2'd0, 2'd0, 16'h0090, 16'h0000, 4'd3}, // R3 list wins over high select
    '{2'd0, 2'd1, 16'h5555, 16'h0000, 4'd3},
    '{2'd1, 2'd0, 16'h0000, 16'h0091, 4'd5}, // R5 index stepped to 1
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd1, 2'd1, 16'h0000, 16'h1111, 4'd3},
    '{2'd1, 2'd1, 16'h0000, 16'h2222, 4'd3},
    '{2'd1, 2'd0, 16'h0000, 16'h0002, 4'd5},
    '{2'd0, 2'd0, 16'h0010, 16'h0000, 4'd3},
    '{2'd1, 2'd1, 16'h0000, 16'hAAAA, 4'd3},
    '{2'd0, 2'd0, 16'h0080, 16'h0000, 4'd3},
    '{2'd1, 2'd1, 16'h0000, 16'h5555, 4'd3},
    '{2'd0, 2'd0, 16'hEF6F, 16'h0000, 4'd2}, // R2 reserved bits set
    '{2'd1, 2'd0, 16'h0000, 16'h000F, 4'd2},
    '{2'd0, 2'd1, 16'h7777, 16'h0000, 4'd5}, // R5 write at index 15
    '{2'd1, 2'd0, 16'h0000, 16'h0000, 4'd5}, // wrapped to 0
    '{2'd0, 2'd0, 16'h000F, 16'h0000, 4'd5},
    '{2'd1, 2'd1, 16'h0000, 16'h7777, 4'd5},
    '{2'd2, 2'd1, 16'h9999, 16'h1111, 4'd7}, // R7 old value returned
    '{2'd1, 2'd0, 16'h0000, 16'h0001, 4'd7},
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd1, 2'd1, 16'h0000, 16'h9999, 4'd7},
    '{2'd0, 2'd2, 16'hFFFF, 16'h0000, 4'd8}, // R8 unmapped write
    '{2'd1, 2'd2, 16'h0000, 16'h0000, 4'd8},
    '{2'd1, 2'd0, 16'h0000, 16'h0001, 4'd8}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [1:0] a, input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(bus_rdata, 16'h0000, "R1 rdata after reset");
    check({15'd0, unit_awake}, 16'h0000, "R1 awake after reset");
    bus_cycle(2'd0, 1'b0, 1'b1, 16'h0);
    check(bus_rdata, 16'h0000, "R1 control after reset");
    bus_cycle(2'd1, 1'b0, 1'b1, 16'h0);
    check(bus_rdata, 16'h0000, "R1 low entry after reset");
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h0010);
    bus_cycle(2'd1, 1'b0, 1'b1, 16'h0);
    check(bus_rdata, 16'h0000, "R1 high entry after reset");
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h0080);
    bus_cycle(2'd1, 1'b0, 1'b1, 16'h0);
    check(bus_rdata, 16'h0000, "R1 list entry after reset");

    do_reset();
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      bus_cycle(v.addr, v.op != 2'd1, v.op != 2'd0, v.wd);
      if (v.op != 2'd0) begin
        checks++;
        if (bus_rdata !== v.exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", v.req, i, bus_rdata, v.exp);
        end
      end
    end

    // R6 read data holds without a read strobe
    wait_edges(3);
    check(bus_rdata, 16'h0001, "R6 rdata held while idle");
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h0000);
    check(bus_rdata, 16'h0001, "R6 rdata unchanged by write");

    // R4 wake-up count
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h1000);
    check({15'd0, unit_awake}, 16'h0000, "R4 awake low just after enable");
    wait_edges(WAKE - 1);
    check({15'd0, unit_awake}, 16'h0000, "R4 awake low at edge 119");
    wait_edges(1);
    check({15'd0, unit_awake}, 16'h0001, "R4 awake high at edge 120");
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h1000);
    check({15'd0, unit_awake}, 16'h0001, "R4 re-enable keeps awake");
    bus_cycle(2'd0, 1'b0, 1'b1, 16'h0);
    check(bus_rdata, 16'h1000, "R2 enable bit reads back");
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h0000);
    check({15'd0, unit_awake}, 16'h0000, "R4 clear drops awake");
    // restart mid-count
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h1000);
    wait_edges(60);
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h0000);
    bus_cycle(2'd0, 1'b1, 1'b0, 16'h1000);
    wait_edges(WAKE - 1);
    check({15'd0, unit_awake}, 16'h0000, "R4 restarted count still low at 119");
    wait_edges(1);
    check({15'd0, unit_awake}, 16'h0001, "R4 restarted count high at 120");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule